// File: doc/BRIEF.md
# Per-Rank DRAM Power-Down Controller

This block decides, for every rank of a single memory channel, when the clock-enable line may drop and which kind of power-down the rank enters. Each rank has its own idle timer. The timer restarts whenever a transaction for that rank arrives or its queue holds work. Once the timer reaches the programmed threshold, the selected policy takes effect. Under the plain fast policy the rank sleeps with its banks left open. Under the precharge policy the block first obtains a precharge-all through a request/grant handshake. Under the DLL-off policy the power-down is marked as DLL-off.

Two hybrid policies start with the fast sleep. When every page-close timer of the rank has expired, the rank is woken and waits the exit time. It then precharges all banks and goes back to a deeper sleep, either precharged or DLL-off. At channel level, an optional flag lets the I/O DLLs be gated while every rank is asleep. When that flag clears, a programmable wake-up count must run out before the I/O path reports ready.

Top module: `rank_pd_ctrl`

## Requirements
- R1: After reset every `cke` bit is 1, `pre_req`, `dll_off` and `io_dll_off` are 0, `rank_ready` is all ones, `io_dll_ready` is 1, and the active policy is "none".
- R2: A rank's idle timer restarts on every clock edge that samples `arrive` high or `queue_empty` low for that rank. If that edge is numbered 0 and nothing further happens, then under the fast policy `cke` falls at edge T+1, where T is the effective threshold.
- R3: The effective threshold is `idle_limit`, except that any value below 15 is raised to 15.
- R4: `mode_sel` encoding: 0 none, 1 fast (banks open), 2 precharged, 3 DLL-off, 4 fast then precharged, 5 fast then DLL-off. Codes 6 and 7 act as 0. Under "none", `cke` never falls.
- R5: Under policy 2, `pre_req` rises when the threshold is reached and stays high, with `cke` high, until an edge samples `pre_gnt`. `pre_req` then drops, and `cke` falls one edge later.
- R6: Under policy 3, `cke` falls with the same timing as policy 1, and `dll_off` is 1 while the rank sleeps. Under policy 1, `dll_off` stays 0.
- R7: Under policies 4 and 5, a sleeping rank wakes (`cke` rises at the next edge) only when all of its page-close flags (`page_expired[r*BANKS +: BANKS]`) are 1. A partial set leaves it asleep.
- R8: After such a wake, `pre_req` rises EXIT_CYC edges after `cke` rises. After the grant the rank re-enters sleep with `dll_off` = 1 for policy 5 and 0 for policy 4, and it stays asleep regardless of the page flags.
- R9: Any edge that samples `arrive` high or `queue_empty` low for a sleeping rank raises its `cke` at that edge. `rank_ready` returns EXIT_CYC edges later.
- R10: With `io_dll_gate_en` high, `io_dll_off` rises one edge after all `cke` are low. It falls one edge after any `cke` rises. `io_dll_ready` then returns `io_dll_wake` edges after that fall. With gating disabled, `io_dll_off` stays 0.
- R11: A new `mode_sel` value takes effect only on an edge at which every `cke` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Power-down policy code |
| idle_limit | input | IDLE_W | Idle threshold in cycles |
| io_dll_gate_en | input | 1 | Allow I/O DLL gating |
| io_dll_wake | input | WAKE_W | I/O DLL wake-up count |
| arrive | input | NUM_RANKS | Transaction arrival strobe per rank |
| queue_empty | input | NUM_RANKS | Rank queue empty flag |
| page_expired | input | NUM_RANKS*BANKS | Page-close timer expired, per bank |
| pre_gnt | input | NUM_RANKS | Precharge-all grant |
| cke | output | NUM_RANKS | Clock-enable level per rank |
| pre_req | output | NUM_RANKS | Precharge-all request |
| dll_off | output | NUM_RANKS | Sleep is DLL-off type |
| rank_ready | output | NUM_RANKS | Rank awake and past exit wait |
| io_dll_off | output | 1 | I/O DLLs may be gated |
| io_dll_ready | output | 1 | I/O DLL wake-up finished |

## Verification
The hardest state to reach is the second half of a hybrid policy. There the rank must already be asleep with its banks open, then see its page flags complete, then run through the exit wait and a held precharge request before the deep sleep. The stimulus first holds the queues busy long enough that the policy latches with every rank awake. It then lets the timers expire and sets the page flags one bit at a time, so the partial case is visited before the full one. The grant is held back for several cycles before it is given. The deferred policy change is reached by changing `mode_sel` while one rank sleeps and another is woken.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic [2:0] {
    PDM_NONE    = 3'd0,
    PDM_FAST    = 3'd1,
    PDM_PRECH   = 3'd2,
    PDM_DLL     = 3'd3,
    PDM_F2PRECH = 3'd4,
    PDM_F2DLL   = 3'd5
  } pd_mode_e;

  typedef enum logic [2:0] {
    RS_ACT,
    RS_EXIT,
    RS_PRE,
    RS_HOLD,
    RS_PDF,
    RS_PDD
  } rank_st_e;
endpackage

// File: rtl/rpd_idle_timer.sv
module rpd_idle_timer #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [IDLE_W-1:0] limit,
  output logic              done
);
  localparam logic [IDLE_W-1:0] CNT_MAX = {IDLE_W{1'b1}};
  logic [IDLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || busy) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);
endmodule

// File: rtl/rpd_rank_fsm.sv
module rpd_rank_fsm
  import rpd_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int EXIT_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  pd_mode_e         mode,
  input  logic             busy,
  input  logic             idle_done,
  input  logic [BANKS-1:0] pages_closed,
  input  logic             pre_gnt,
  output logic             cke,
  output logic             pre_req,
  output logic             dll_off,
  output logic             ready
);
  localparam int EW = (EXIT_CYC < 2) ? 1 : $clog2(EXIT_CYC);
  localparam logic [EW-1:0] EXIT_LAST = EW'(EXIT_CYC - 1);

  rank_st_e     st;
  logic [EW-1:0] ecnt;
  logic          resume;
  logic          dll_q;
  logic          hybrid;

  assign hybrid = (mode == PDM_F2PRECH) || (mode == PDM_F2DLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RS_ACT;
      ecnt   <= '0;
      resume <= 1'b0;
      dll_q  <= 1'b0;
    end else begin
      case (st)
        RS_ACT: begin
          if (!busy && idle_done) begin
            case (mode)
              PDM_NONE:  st <= RS_ACT;
              PDM_PRECH: st <= RS_PRE;
              default: begin
                st    <= RS_PDF;
                dll_q <= (mode == PDM_DLL);
              end
            endcase
          end
        end
        RS_PDF: begin
          if (busy) begin
            st     <= RS_EXIT;
            ecnt   <= '0;
            resume <= 1'b0;
            dll_q  <= 1'b0;
          end else if (hybrid && (&pages_closed)) begin
            st     <= RS_EXIT;
            ecnt   <= '0;
            resume <= 1'b1;
            dll_q  <= 1'b0;
          end
        end
        RS_EXIT: begin
          if (ecnt == EXIT_LAST) begin
            st     <= resume ? RS_PRE : RS_ACT;
            resume <= 1'b0;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        RS_PRE: begin
          if (pre_gnt) st <= RS_HOLD;
        end
        RS_HOLD: begin
          if (busy) st <= RS_ACT;
          else begin
            st    <= RS_PDD;
            dll_q <= (mode == PDM_DLL) || (mode == PDM_F2DLL);
          end
        end
        RS_PDD: begin
          if (busy) begin
            st     <= RS_EXIT;
            ecnt   <= '0;
            resume <= 1'b0;
            dll_q  <= 1'b0;
          end
        end
        default: st <= RS_ACT;
      endcase
    end
  end

  assign cke     = !((st == RS_PDF) || (st == RS_PDD));
  assign pre_req = (st == RS_PRE);
  assign dll_off = dll_q;
  assign ready   = (st == RS_ACT);
endmodule

// File: rtl/rpd_io_dll_gate.sv
module rpd_io_dll_gate #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              all_asleep,
  input  logic              gate_en,
  input  logic [WAKE_W-1:0] wake,
  output logic              off,
  output logic              ready
);
  logic [WAKE_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      off  <= 1'b0;
      wcnt <= '0;
    end else if (off) begin
      if (!(gate_en && all_asleep)) begin
        off  <= 1'b0;
        wcnt <= wake;
      end
    end else begin
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      if (gate_en && all_asleep) off <= 1'b1;
    end
  end

  assign ready = !off && (wcnt == '0);
endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl
  import rpd_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int BANKS     = 4,
  parameter int EXIT_CYC  = 3,
  parameter int IDLE_W    = 8,
  parameter int MIN_IDLE  = 15,
  parameter int WAKE_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 mode_sel,
  input  logic [IDLE_W-1:0]          idle_limit,
  input  logic                       io_dll_gate_en,
  input  logic [WAKE_W-1:0]          io_dll_wake,
  input  logic [NUM_RANKS-1:0]       arrive,
  input  logic [NUM_RANKS-1:0]       queue_empty,
  input  logic [NUM_RANKS*BANKS-1:0] page_expired,
  input  logic [NUM_RANKS-1:0]       pre_gnt,
  output logic [NUM_RANKS-1:0]       cke,
  output logic [NUM_RANKS-1:0]       pre_req,
  output logic [NUM_RANKS-1:0]       dll_off,
  output logic [NUM_RANKS-1:0]       rank_ready,
  output logic                       io_dll_off,
  output logic                       io_dll_ready
);
  localparam logic [IDLE_W-1:0] FLOOR = IDLE_W'(MIN_IDLE);

  logic [IDLE_W-1:0] thr;
  pd_mode_e          mode_q;
  pd_mode_e          mode_dec;
  logic [NUM_RANKS-1:0] busy;
  logic [NUM_RANKS-1:0] idle_done;

  assign thr  = (idle_limit < FLOOR) ? FLOOR : idle_limit;
  assign busy = arrive | ~queue_empty;

  always_comb begin
    case (mode_sel)
      3'd1:    mode_dec = PDM_FAST;
      3'd2:    mode_dec = PDM_PRECH;
      3'd3:    mode_dec = PDM_DLL;
      3'd4:    mode_dec = PDM_F2PRECH;
      3'd5:    mode_dec = PDM_F2DLL;
      default: mode_dec = PDM_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PDM_NONE;
    else if (&cke) mode_q <= mode_dec;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rpd_idle_timer #(.IDLE_W(IDLE_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .busy  (busy[r]),
      .limit (thr),
      .done  (idle_done[r])
    );

    rpd_rank_fsm #(.BANKS(BANKS), .EXIT_CYC(EXIT_CYC)) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .mode         (mode_q),
      .busy         (busy[r]),
      .idle_done    (idle_done[r]),
      .pages_closed (page_expired[r*BANKS +: BANKS]),
      .pre_gnt      (pre_gnt[r]),
      .cke          (cke[r]),
      .pre_req      (pre_req[r]),
      .dll_off      (dll_off[r]),
      .ready        (rank_ready[r])
    );
  end

  rpd_io_dll_gate #(.WAKE_W(WAKE_W)) u_iodll (
    .clk        (clk),
    .rst        (rst),
    .all_asleep (~|cke),
    .gate_en    (io_dll_gate_en),
    .wake       (io_dll_wake),
    .off        (io_dll_off),
    .ready      (io_dll_ready)
  );
endmodule

// File: rtl/rank_pd_ctrl_chk.sv
module rank_pd_ctrl_chk #(
  parameter int NUM_RANKS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_RANKS-1:0] arrive,
  input logic [NUM_RANKS-1:0] queue_empty,
  input logic [NUM_RANKS-1:0] pre_gnt,
  input logic [NUM_RANKS-1:0] cke,
  input logic [NUM_RANKS-1:0] pre_req,
  input logic [NUM_RANKS-1:0] dll_off,
  input logic                 io_dll_off
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
      (pre_req[r] && !pre_gnt[r]) |=> pre_req[r]);
    a_r5_cke_after_grant: assert property (@(posedge clk) disable iff (rst)
      (pre_req[r] && pre_gnt[r]) |=> (cke[r] && !pre_req[r]));
    a_r5_req_awake: assert property (@(posedge clk) disable iff (rst)
      pre_req[r] |-> cke[r]);
    a_r6_dll_asleep: assert property (@(posedge clk) disable iff (rst)
      dll_off[r] |-> !cke[r]);
    a_r9_busy_wakes: assert property (@(posedge clk) disable iff (rst)
      (arrive[r] || !queue_empty[r]) |=> cke[r]);
  end

  a_r10_gate_all_asleep: assert property (@(posedge clk) disable iff (rst)
    $rose(io_dll_off) |-> ($past(cke) == '0));
endmodule

bind rank_pd_ctrl rank_pd_ctrl_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .arrive      (arrive),
  .queue_empty (queue_empty),
  .pre_gnt     (pre_gnt),
  .cke         (cke),
  .pre_req     (pre_req),
  .dll_off     (dll_off),
  .io_dll_off  (io_dll_off)
);

// File: tb/rank_pd_ctrl_test.sv
module rank_pd_ctrl_test;
  localparam int NR = 2;
  localparam int NB = 2;
  localparam int EXC = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    mode_sel;
  logic [7:0]    idle_limit;
  logic          io_dll_gate_en;
  logic [7:0]    io_dll_wake;
  logic [NR-1:0] arrive;
  logic [NR-1:0] queue_empty;
  logic [NR*NB-1:0] page_expired;
  logic [NR-1:0] pre_gnt;
  logic [NR-1:0] cke, pre_req, dll_off, rank_ready;
  logic          io_dll_off, io_dll_ready;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rank_pd_ctrl #(.NUM_RANKS(NR), .BANKS(NB), .EXIT_CYC(EXC)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .idle_limit(idle_limit),
    .io_dll_gate_en(io_dll_gate_en), .io_dll_wake(io_dll_wake),
    .arrive(arrive), .queue_empty(queue_empty), .page_expired(page_expired),
    .pre_gnt(pre_gnt), .cke(cke), .pre_req(pre_req), .dll_off(dll_off),
    .rank_ready(rank_ready), .io_dll_off(io_dll_off), .io_dll_ready(io_dll_ready)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wake_then_idle(input logic [NR-1:0] mask);
    queue_empty = ~mask;
    repeat (8) tick();
    queue_empty = '1;
  endtask

  task automatic measure_fall(input int r, output int n);
    n = 0;
    while (cke[r] && n < 600) begin
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int vals[6];
    vals = '{0, 3, 14, 15, 16, 40};
    rst = 1'b1; mode_sel = 3'd0; idle_limit = 8'd15; io_dll_gate_en = 1'b0;
    io_dll_wake = 8'd5; arrive = '0; queue_empty = '1; page_expired = '0; pre_gnt = '0;
    #1;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1", "cke", int'(cke), 3);
    chk("R1", "pre_req", int'(pre_req), 0);
    chk("R1", "dll_off", int'(dll_off), 0);
    chk("R1", "rank_ready", int'(rank_ready), 3);
    chk("R1", "io_dll_off", int'(io_dll_off), 0);
    chk("R1", "io_dll_ready", int'(io_dll_ready), 1);

    // R4: policy none and codes 6/7 never sleep
    repeat (300) tick();
    chk("R4", "cke mode0", int'(cke), 3);
    mode_sel = 3'd7;
    wake_then_idle('1);
    repeat (300) tick();
    chk("R4", "cke mode7", int'(cke), 3);
    mode_sel = 3'd6;
    wake_then_idle('1);
    repeat (300) tick();
    chk("R4", "cke mode6", int'(cke), 3);

    // R2 / R3: threshold sweep under fast policy
    mode_sel = 3'd1;
    foreach (vals[i]) begin
      idle_limit = 8'(vals[i]);
      wake_then_idle('1);
      measure_fall(0, n);
      chk("R3", $sformatf("fall edges lim=%0d", vals[i]), n, ((vals[i] < 15) ? 15 : vals[i]) + 1);
      chk("R2", "rank1 fell together", int'(cke[1]), 0);
      chk("R6", "fast dll_off", int'(dll_off[0]), 0);
    end
    idle_limit = 8'd15;

    // R2: arrival restarts timer
    wake_then_idle('1);
    repeat (10) tick();
    arrive[0] = 1'b1; tick(); arrive = '0;
    measure_fall(0, n);
    chk("R2", "restart after arrive", n, 16);

    // R9: wake from sleep and exit wait
    arrive[0] = 1'b1; tick(); arrive = '0;
    chk("R9", "cke up", int'(cke[0]), 1);
    chk("R9", "not ready", int'(rank_ready[0]), 0);
    tick();
    chk("R9", "still not ready", int'(rank_ready[0]), 0);
    tick();
    chk("R9", "ready", int'(rank_ready[0]), 1);

    // R6: DLL-off policy
    mode_sel = 3'd3;
    wake_then_idle('1);
    measure_fall(0, n);
    chk("R6", "dll mode fall", n, 16);
    chk("R6", "dll_off set", int'(dll_off[0]), 1);
    arrive[0] = 1'b1; tick(); arrive = '0;
    chk("R6", "dll_off cleared on wake", int'(dll_off[0]), 0);

    // R5: precharged policy
    mode_sel = 3'd2;
    wake_then_idle('1);
    repeat (15) tick();
    chk("R5", "no req yet", int'(pre_req[0]), 0);
    tick();
    chk("R5", "req up", int'(pre_req[0]), 1);
    chk("R5", "cke high with req", int'(cke[0]), 1);
    repeat (3) tick();
    chk("R5", "req held", int'(pre_req[0]), 1);
    chk("R5", "cke held", int'(cke[0]), 1);
    pre_gnt[0] = 1'b1; tick(); pre_gnt = '0;
    chk("R5", "req dropped", int'(pre_req[0]), 0);
    chk("R5", "cke grant+0", int'(cke[0]), 1);
    tick();
    chk("R5", "cke grant+1", int'(cke[0]), 0);
    chk("R5", "precharged dll_off", int'(dll_off[0]), 0);
    pre_gnt[1] = 1'b1; tick(); pre_gnt = '0; tick();

    // R7 / R8: hybrid policies
    for (int m = 4; m <= 5; m++) begin
      mode_sel = 3'(m);
      page_expired = '0;
      wake_then_idle('1);
      measure_fall(0, n);
      chk("R7", $sformatf("hybrid%0d fast fall", m), n, 16);
      chk("R7", "fast dll_off", int'(dll_off[0]), 0);
      page_expired[0] = 1'b1;
      repeat (5) tick();
      chk("R7", "partial pages stay asleep", int'(cke[0]), 0);
      page_expired[1:0] = 2'b11;
      tick();
      chk("R7", "all pages wake", int'(cke[0]), 1);
      chk("R8", "not ready in exit", int'(rank_ready[0]), 0);
      tick();
      chk("R8", "no req during exit", int'(pre_req[0]), 0);
      tick();
      chk("R8", "req after exit", int'(pre_req[0]), 1);
      pre_gnt[0] = 1'b1; tick(); pre_gnt = '0;
      chk("R8", "cke grant+0", int'(cke[0]), 1);
      tick();
      chk("R8", "deep sleep", int'(cke[0]), 0);
      chk("R8", "deep dll_off", int'(dll_off[0]), (m == 5) ? 1 : 0);
      repeat (10) tick();
      chk("R8", "stays deep", int'(cke[0]), 0);
      page_expired = '0;
    end

    // R11: policy change deferred while a rank sleeps
    mode_sel = 3'd1;
    wake_then_idle('1);
    measure_fall(0, n);
    chk("R11", "both asleep", int'(cke), 0);
    mode_sel = 3'd0;
    wake_then_idle(2'b01);
    measure_fall(0, n);
    chk("R11", "old policy kept", n, 16);
    wake_then_idle('1);
    repeat (300) tick();
    chk("R11", "new policy applied", int'(cke), 3);

    // R10: I/O DLL gating
    mode_sel = 3'd1;
    io_dll_gate_en = 1'b0;
    io_dll_wake = 8'd5;
    wake_then_idle('1);
    repeat (20) tick();
    chk("R10", "all asleep", int'(cke), 0);
    chk("R10", "gate disabled", int'(io_dll_off), 0);
    io_dll_gate_en = 1'b1;
    tick();
    chk("R10", "gated", int'(io_dll_off), 1);
    chk("R10", "not ready while gated", int'(io_dll_ready), 0);
    arrive[0] = 1'b1; tick(); arrive = '0;
    chk("R10", "off one more edge", int'(io_dll_off), 1);
    tick();
    chk("R10", "off cleared", int'(io_dll_off), 0);
    chk("R10", "wake pending", int'(io_dll_ready), 0);
    repeat (4) tick();
    chk("R10", "wake pending late", int'(io_dll_ready), 0);
    tick();
    chk("R10", "wake done", int'(io_dll_ready), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule